// File: doc/BRIEF.md
# Dual-Window Video Memory Bank Mapper

The mapper turns a 16-bit offset inside a 64 KB host graphics aperture into a full video-memory address. It adds a bank base, a multiple of 64 KB, to the offset. Host writes always take their base from a write-bank register. Host reads take their base from a separate read-bank register, but only while a split-mode bit is set. While that bit is clear, reads use the write base as well.

The two bank registers are loaded through a byte-wide I/O port interface. The read bank sits at port 0x3D6 and the write bank at 0x3D7, and both read back on the same interface. The split-mode bit is bit 2 of an extended graphics-controller register, delivered on a dedicated write strobe.

Each register write refreshes the registered bank bases at the same clock edge, so the next host access uses the new mapping. The summed address is wrapped to the installed memory size, which is a parameter given in kilobytes.

Top module: `vram_bank_mapper`

## Requirements
- R1: A host write (`host_wr` high) is mapped to `(W*65536 + host_ofs) mod VRAM_BYTES`. Here W is bits [3:0] of the write-bank register at I/O port 0x3D7.
- R2: While the split bit is 1, a host read (`host_rd` high, `host_wr` low) is mapped to `(R*65536 + host_ofs) mod VRAM_BYTES`. Here R is bits [3:0] of the read-bank register at I/O port 0x3D6.
- R3: While the split bit is 0, a host read is mapped exactly as a write would be, using W.
- R4: With `io_addr` = 0x3D6 or 0x3D7, `io_rdata` returns the full 8-bit value last written to that port. Any other port reads 0x00, and writes to any other port change neither register nor any mapping.
- R5: A register or split-bit write takes effect at the clock edge that samples it. Before that edge the mapping is the old one; from that edge on it is the new one. Without a write, the bases stay unchanged.
- R6: Bits [15:0] of `vram_addr` always equal `host_ofs`. The wider sum wraps at VRAM_BYTES = VRAM_KB*1024.
- R7: Reset clears both bank registers and the split bit, so every access maps to `host_ofs` and both ports read 0x00.
- R8: Bits [7:4] of either bank register are stored and read back but have no effect on any mapping.
- R9: When `host_wr` and `host_rd` are both high, the write base is used. `vram_acc` is high whenever either strobe is high.
- R10: A `gfx_ext_we` pulse loads the split bit from bit 2 of `gfx_ext_wdata`. The other bits of that byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_we | input | 1 | I/O port write strobe |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O readback data, combinational from `io_addr` |
| gfx_ext_we | input | 1 | Write strobe for the extended graphics register holding the split bit |
| gfx_ext_wdata | input | 8 | Data for that register; bit 2 is the split bit |
| host_rd | input | 1 | Host aperture read |
| host_wr | input | 1 | Host aperture write |
| host_ofs | input | 16 | Offset inside the 64 KB aperture |
| vram_acc | output | 1 | An aperture access is in progress |
| vram_addr | output | ADDR_W | Mapped video-memory address |

## Verification
The address path is combinational from the host inputs and the registered bases. The bench therefore settles each probe 1 ns after it drives the inputs, and samples between clock edges.

A register write is driven at a falling edge and committed by the next rising edge. Its result is due from that rising edge on. The bench checks once while the write is still pending, expecting the old mapping, and again at the following falling edge, expecting the new one.

The readback is also combinational, and is sampled the same way, after a write has been committed.

// File: rtl/vbm_pkg.sv
package vbm_pkg;

  localparam int OFS_W      = 16;
  localparam int BANK_REG_W = 8;
  localparam int BANK_SEL_W = 4;
  localparam int BASE_W     = OFS_W + BANK_SEL_W;
  localparam int SPLIT_BIT  = 2;

  typedef struct packed {
    logic [BANK_REG_W-1:0] rbank;
    logic [BANK_REG_W-1:0] wbank;
    logic                  split;
  } bank_state_t;

  // Bank register value to a 64 KB aligned base; upper bits are dropped.
  function automatic logic [BASE_W-1:0] bank_to_base(input logic [BANK_REG_W-1:0] val);
    return {val[BANK_SEL_W-1:0], {OFS_W{1'b0}}};
  endfunction

  // Base plus aperture offset, wrapped by the installed-size mask.
  function automatic logic [BASE_W-1:0] compose_addr(input logic [BASE_W-1:0] base,
                                                     input logic [OFS_W-1:0]  ofs,
                                                     input logic [BASE_W-1:0] mask);
    logic [BASE_W-1:0] sum;
    sum = base + {{BANK_SEL_W{1'b0}}, ofs};
    return sum & mask;
  endfunction

endpackage

// File: rtl/vbm_bank_regs.sv
module vbm_bank_regs
  import vbm_pkg::*;
#(
  parameter logic [15:0] RD_PORT = 16'h03D6,
  parameter logic [15:0] WR_PORT = 16'h03D7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  io_we,
  input  logic [15:0]           io_addr,
  input  logic [BANK_REG_W-1:0] io_wdata,
  input  logic                  gfx_ext_we,
  input  logic [BANK_REG_W-1:0] gfx_ext_wdata,
  output bank_state_t           state_q,
  output bank_state_t           state_d,
  output logic                  cfg_event,
  output logic [BANK_REG_W-1:0] io_rdata
);

  logic hit_rd;
  logic hit_wr;

  assign hit_rd    = io_we && (io_addr == RD_PORT);
  assign hit_wr    = io_we && (io_addr == WR_PORT);
  assign cfg_event = hit_rd || hit_wr || gfx_ext_we;

  always_comb begin
    state_d = state_q;
    if (hit_rd)     state_d.rbank = io_wdata;
    if (hit_wr)     state_d.wbank = io_wdata;
    if (gfx_ext_we) state_d.split = gfx_ext_wdata[SPLIT_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  always_comb begin
    if (io_addr == RD_PORT)      io_rdata = state_q.rbank;
    else if (io_addr == WR_PORT) io_rdata = state_q.wbank;
    else                         io_rdata = '0;
  end

endmodule

// File: rtl/vbm_base_calc.sv
module vbm_base_calc
  import vbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bank_state_t       state_d,
  input  logic              cfg_event,
  output logic [BASE_W-1:0] wr_base,
  output logic [BASE_W-1:0] rd_base
);

  logic [BASE_W-1:0] wr_next;
  logic [BASE_W-1:0] rd_next;

  always_comb begin
    wr_next = bank_to_base(state_d.wbank);
    rd_next = state_d.split ? bank_to_base(state_d.rbank) : wr_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_base <= '0;
      rd_base <= '0;
    end else if (cfg_event) begin
      wr_base <= wr_next;
      rd_base <= rd_next;
    end
  end

endmodule

// File: rtl/vbm_addr_gen.sv
module vbm_addr_gen
  import vbm_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [OFS_W-1:0]  host_ofs,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [BASE_W-1:0] rd_base,
  input  logic [BASE_W-1:0] size_mask,
  output logic              use_wr_bank,
  output logic              vram_acc,
  output logic [ADDR_W-1:0] vram_addr
);

  logic [BASE_W-1:0] sel_base;
  logic [BASE_W-1:0] full_addr;

  assign use_wr_bank = host_wr;
  assign vram_acc    = host_rd || host_wr;
  assign sel_base    = use_wr_bank ? wr_base : rd_base;
  assign full_addr   = compose_addr(sel_base, host_ofs, size_mask);

  generate
    if (ADDR_W >= BASE_W) begin : g_wide
      assign vram_addr = {{(ADDR_W-BASE_W){1'b0}}, full_addr};
    end else begin : g_narrow
      assign vram_addr = full_addr[ADDR_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/vram_bank_mapper.sv
module vram_bank_mapper
  import vbm_pkg::*;
#(
  parameter int          VRAM_KB = 1024,
  parameter logic [15:0] RD_PORT = 16'h03D6,
  parameter logic [15:0] WR_PORT = 16'h03D7,
  localparam int         VRAM_BYTES = VRAM_KB * 1024,
  localparam int         ADDR_W     = $clog2(VRAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_we,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              gfx_ext_we,
  input  logic [7:0]        gfx_ext_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [15:0]       host_ofs,
  output logic              vram_acc,
  output logic [ADDR_W-1:0] vram_addr
);

  localparam logic [BASE_W-1:0] SIZE_MASK = BASE_W'(VRAM_BYTES - 1);

  bank_state_t       state_q;
  bank_state_t       state_d;
  logic              cfg_event;
  logic [BASE_W-1:0] wr_base;
  logic [BASE_W-1:0] rd_base;
  logic              use_wr_bank;
  logic              split_q;

  assign split_q = state_q.split;

  vbm_bank_regs #(.RD_PORT(RD_PORT), .WR_PORT(WR_PORT)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_we         (io_we),
    .io_addr       (io_addr),
    .io_wdata      (io_wdata),
    .gfx_ext_we    (gfx_ext_we),
    .gfx_ext_wdata (gfx_ext_wdata),
    .state_q       (state_q),
    .state_d       (state_d),
    .cfg_event     (cfg_event),
    .io_rdata      (io_rdata)
  );

  vbm_base_calc u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_d   (state_d),
    .cfg_event (cfg_event),
    .wr_base   (wr_base),
    .rd_base   (rd_base)
  );

  vbm_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .host_rd     (host_rd),
    .host_wr     (host_wr),
    .host_ofs    (host_ofs),
    .wr_base     (wr_base),
    .rd_base     (rd_base),
    .size_mask   (SIZE_MASK),
    .use_wr_bank (use_wr_bank),
    .vram_acc    (vram_acc),
    .vram_addr   (vram_addr)
  );

endmodule

// File: rtl/vbm_checker.sv
module vbm_checker
  import vbm_pkg::*;
#(
  parameter int          ADDR_W  = 20,
  parameter logic [15:0] RD_PORT = 16'h03D6,
  parameter logic [15:0] WR_PORT = 16'h03D7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_we,
  input logic [15:0]       io_addr,
  input logic [7:0]        io_wdata,
  input logic              gfx_ext_we,
  input logic              host_rd,
  input logic              host_wr,
  input logic [15:0]       host_ofs,
  input logic [ADDR_W-1:0] vram_addr,
  input logic [BASE_W-1:0] wr_base,
  input logic [BASE_W-1:0] rd_base,
  input logic              split_q
);

  AST_WBASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == WR_PORT) |=> (wr_base == {$past(io_wdata[3:0]), 16'h0000})); // R1

  AST_RBASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == RD_PORT && split_q && !gfx_ext_we) |=> (rd_base == {$past(io_wdata[3:0]), 16'h0000})); // R2

  AST_RBASE_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    !split_q |-> (rd_base == wr_base)); // R3

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_we && !gfx_ext_we) |=> ($stable(wr_base) && $stable(rd_base))); // R5

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd || host_wr) |-> (vram_addr[15:0] == host_ofs)); // R6

endmodule

bind vram_bank_mapper vbm_checker #(.ADDR_W(ADDR_W), .RD_PORT(RD_PORT), .WR_PORT(WR_PORT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_we      (io_we),
  .io_addr    (io_addr),
  .io_wdata   (io_wdata),
  .gfx_ext_we (gfx_ext_we),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_ofs   (host_ofs),
  .vram_addr  (vram_addr),
  .wr_base    (wr_base),
  .rd_base    (rd_base),
  .split_q    (split_q)
);

// File: tb/sim_vram_bank_mapper.sv
`timescale 1ns/1ps
module sim_vram_bank_mapper;

  localparam int KB     = 512;
  localparam int BYTES  = KB * 1024;
  localparam int AW     = $clog2(BYTES);
  localparam logic [15:0] PR = 16'h03D6;
  localparam logic [15:0] PW = 16'h03D7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          io_we = 1'b0;
  logic [15:0]   io_addr = '0;
  logic [7:0]    io_wdata = '0;
  logic [7:0]    io_rdata;
  logic          gfx_ext_we = 1'b0;
  logic [7:0]    gfx_ext_wdata = '0;
  logic          host_rd = 1'b0;
  logic          host_wr = 1'b0;
  logic [15:0]   host_ofs = '0;
  logic          vram_acc;
  logic [AW-1:0] vram_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  vram_bank_mapper #(.VRAM_KB(KB)) u0 (.*);

  function automatic int expect_addr(input int bank, input int ofs);
    return (bank * 65536 + ofs) % BYTES;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_we = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_we = 1'b0;
  endtask

  task automatic gfx_wr(input logic [7:0] d);
    @(negedge clk);
    gfx_ext_we = 1'b1; gfx_ext_wdata = d;
    @(negedge clk);
    gfx_ext_we = 1'b0;
  endtask

  task automatic probe(input logic wr, input logic rd, input logic [15:0] ofs,
                       output logic [31:0] a);
    host_wr = wr; host_rd = rd; host_ofs = ofs;
    #1;
    a = 32'(vram_addr);
  endtask

  task automatic rdback(input logic [15:0] a, output logic [31:0] d);
    io_addr = a;
    #1;
    d = 32'(io_rdata);
  endtask

  initial begin : wdog
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int ofs_list[4] = '{0, 1, 32768, 65535};
    logic [31:0] got;
    logic [31:0] got2;
    int wsel;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state
    rdback(PR, got);  chk("R7 rbank reset", got, 0);
    rdback(PW, got);  chk("R7 wbank reset", got, 0);
    probe(0, 1, 16'h1234, got); chk("R7 read map", got, 32'h1234);
    probe(1, 0, 16'hBEEF, got); chk("R7 write map", got, 32'hBEEF);
    chk("R9 acc", 32'(vram_acc), 1);
    probe(0, 0, 16'h0, got); chk("R9 idle acc", 32'(vram_acc), 0);

    // R1, R3, R4, R8: shared mode sweep
    for (int w = 0; w < 16; w++) begin
      io_wr(PW, {4'(w) ^ 4'hA, 4'(w)});
      rdback(PW, got); chk("R4 wbank readback", got, 32'({4'(w) ^ 4'hA, 4'(w)}));
      foreach (ofs_list[i]) begin
        probe(1, 0, 16'(ofs_list[i]), got); chk("R1 write map", got, 32'(expect_addr(w, ofs_list[i])));
        probe(0, 1, 16'(ofs_list[i]), got); chk("R3 read shares", got, 32'(expect_addr(w, ofs_list[i])));
        chk("R6 low bits", got & 32'hFFFF, 32'(ofs_list[i]));
      end
    end

    // R10: split bit from bit 2 only
    gfx_wr(8'h04);
    // R2, R9: split mode sweep
    for (int r = 0; r < 16; r++) begin
      wsel = (r + 3) % 16;
      io_wr(PR, {4'(15 - r), 4'(r)});
      io_wr(PW, {4'(r), 4'(wsel)});
      rdback(PR, got); chk("R4 rbank readback", got, 32'({4'(15 - r), 4'(r)}));
      foreach (ofs_list[i]) begin
        probe(0, 1, 16'(ofs_list[i]), got); chk("R2 split read", got, 32'(expect_addr(r, ofs_list[i])));
        probe(1, 0, 16'(ofs_list[i]), got); chk("R1 split write", got, 32'(expect_addr(wsel, ofs_list[i])));
        probe(1, 1, 16'(ofs_list[i]), got); chk("R9 both strobes", got, 32'(expect_addr(wsel, ofs_list[i])));
      end
    end

    // R8: upper nibble has no effect (state now r=15, w=2)
    io_wr(PR, 8'h5B);
    probe(0, 1, 16'h0042, got);
    io_wr(PR, 8'hCB);
    probe(0, 1, 16'h0042, got2);
    chk("R8 upper nibble", got2, got);
    chk("R8 map value", got2, 32'(expect_addr(11, 16'h42)));

    // R10: other bits of the graphics byte ignored, bit 2 clear -> shared
    gfx_wr(8'hFB);
    probe(0, 1, 16'h0042, got); chk("R10 split cleared", got, 32'(expect_addr(2, 16'h42)));
    chk("R3 read shares after clear", got, 32'(expect_addr(2, 16'h42)));
    gfx_wr(8'h04);
    probe(0, 1, 16'h0042, got); chk("R10 split set", got, 32'(expect_addr(11, 16'h42)));

    // R5: timing of a write
    @(negedge clk);
    io_we = 1'b1; io_addr = PW; io_wdata = 8'h07;
    probe(1, 0, 16'h0010, got); chk("R5 before edge", got, 32'(expect_addr(2, 16'h10)));
    @(negedge clk);
    io_we = 1'b0;
    probe(1, 0, 16'h0010, got); chk("R5 after edge", got, 32'(expect_addr(7, 16'h10)));
    repeat (3) @(negedge clk);
    probe(1, 0, 16'h0010, got); chk("R5 holds", got, 32'(expect_addr(7, 16'h10)));

    // R4: writes elsewhere are ignored
    io_wr(16'h03D5, 8'h0F);
    io_wr(16'h03D8, 8'h0E);
    rdback(PW, got);  chk("R4 wbank untouched", got, 32'h07);
    rdback(PR, got);  chk("R4 rbank untouched", got, 32'hCB);
    rdback(16'h03D5, got); chk("R4 other port reads 0", got, 0);
    probe(1, 0, 16'h0010, got); chk("R4 write map untouched", got, 32'(expect_addr(7, 16'h10)));
    probe(0, 1, 16'h0010, got); chk("R4 read map untouched", got, 32'(expect_addr(11, 16'h10)));

    // R7: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rdback(PR, got); chk("R7 rbank cleared", got, 0);
    rdback(PW, got); chk("R7 wbank cleared", got, 0);
    probe(0, 1, 16'h7777, got); chk("R7 read map cleared", got, 32'h7777);
    io_wr(PR, 8'h03);
    probe(0, 1, 16'h7777, got); chk("R7 split cleared by reset", got, 32'h7777);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule